// File: doc/BRIEF.md
# Vector Remap Configuration Decoder

This block takes the decoded fields of an index-remap setup operation and, on a one-cycle execute strobe, updates two kinds of configuration state. The first is a state word. It holds a persist flag, a five-bit vector that enables remapping per operand slot, and five 2-bit selectors. Each selector names the shape register used by one slot. There are three input slots (in0, in1, in2) and two output slots (out0, out1). The second is a bank of shape registers. Each one holds an index-register base, x and y dimensions, a skip code, an invert field, an order flag and an index element-width code.

The slot mask has two interpretations, chosen by a mode bit. In enable mode each mask bit switches one slot on. Each enabled slot among the first four is pointed at the shape register with its own number, and all enabled shapes receive the same contents. In select mode the mask is packed: its top three bits name a single slot and its low bits name a single shape. Only that shape is written. Every other shape and every other selector is cleared.

A shape index input reads back any shape register combinationally. The state word is always visible on its own outputs.

Top module: `remap_cfg_decoder`

## Requirements
- R1: Reset clears the persist flag, the enable vector, all selectors and every field of every shape register to zero.
- R2: On an execute strobe the persist flag takes the value of the mode bit `mm_i`.
- R3: With `mm_i`=0, the enable vector takes `mask_i[4:0]` unchanged. Bit 0 is in0, bit 1 is in1, bit 2 is in2, bit 3 is out0 and bit 4 is out1.
- R4: With `mm_i`=0, each enabled slot k with k<4 gets selector value k. The out1 selector and the selectors of disabled slots read 0. Slot k's selector occupies `sel_o[2k+1:2k]`.
- R5: With `mm_i`=1, `mask_i[4:2]` is a slot code (0=in0, 1=in1, 2=in2, 3=out0, 4=out1) and `mask_i[1:0]` is a shape number. Only the coded slot's enable bit is set, its selector takes the shape number, and all other selectors read 0.
- R6: With `mm_i`=1 and a slot code of 5, 6 or 7, the enable vector and all selectors become 0. The shape named by `mask_i[1:0]` is still written.
- R7: A written shape's base field is `grp_i` shifted left by one bit.
- R8: A written shape with `yx_i`=0 gets x dimension `dim_i`, y dimension 1 and order 0. With `yx_i`=1 it gets x dimension 1, y dimension `dim_i` and order 1.
- R9: A written shape stores `skip_i` and the element-width code `ew_i` (0=64-bit, 1=32-bit, 2=16-bit, 3=8-bit), and its invert field is 0.
- R10: With `mm_i`=0, shape s (s<4) is written when mask bit s is set and is cleared to all zeros otherwise.
- R11: With `mm_i`=1, only the shape named by `mask_i[1:0]` is written, and every other shape is cleared to all zeros.
- R12: Without an execute strobe, no state or shape field changes, whatever the other inputs do.
- R13: The readback outputs show the shape selected by `rd_idx_i` in the same cycle the index is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exec_i | input | 1 | One-cycle execute strobe; commits all updates |
| grp_i | input | GRP_W | Index register group |
| mask_i | input | SEL_W+3 | Slot mask, enable or packed form |
| dim_i | input | DIM_W | Dimension size |
| ew_i | input | 2 | Index element-width code |
| yx_i | input | 1 | Axis swap flag |
| mm_i | input | 1 | Mask mode: 0 enable, 1 select |
| skip_i | input | SKIP_W | Skip code |
| persist_o | output | 1 | Persist flag |
| en_o | output | 5 | Per-slot remap enable |
| sel_o | output | 5*SEL_W | Per-slot shape selectors, slot k at bits k*SEL_W |
| rd_idx_i | input | SEL_W | Shape register to read back |
| rd_base_o | output | GRP_W+1 | Selected shape base |
| rd_xdim_o | output | DIM_W | Selected shape x dimension |
| rd_ydim_o | output | DIM_W | Selected shape y dimension |
| rd_skip_o | output | SKIP_W | Selected shape skip |
| rd_inv_o | output | INV_W | Selected shape invert field |
| rd_order_o | output | 1 | Selected shape order flag |
| rd_ew_o | output | 2 | Selected shape element-width code |

## Verification
Each update is stored at the first rising edge on which `exec_i` is high. The state outputs therefore carry the new values from that edge on, and so do the readback outputs for the default combinational readback. Every scenario raises `exec_i` at a falling edge and drops it at the next falling edge, and the state checks sample there, half a period after the committing edge. Shape checks change `rd_idx_i` while the clock is low and sample one nanosecond later, before any further edge. Because of this, readback is tested with no clock edge in between, and the hold scenario leaves several edges with `exec_i` low before it samples.

// File: rtl/remap_cfg_pkg.sv
package remap_cfg_pkg;

   localparam int NUM_SLOTS   = 5;
   localparam int NUM_DIRECT  = 4;
   localparam int SLOT_CODE_W = 3;
   localparam int EW_W        = 2;

   typedef enum logic [SLOT_CODE_W-1:0] {
      SLOT_IN0  = 3'd0,
      SLOT_IN1  = 3'd1,
      SLOT_IN2  = 3'd2,
      SLOT_OUT0 = 3'd3,
      SLOT_OUT1 = 3'd4
   } slot_e;

   typedef enum logic [EW_W-1:0] {
      EW_64 = 2'd0,
      EW_32 = 2'd1,
      EW_16 = 2'd2,
      EW_8  = 2'd3
   } elem_w_e;

   typedef enum logic {
      ORD_XY = 1'b0,
      ORD_YX = 1'b1
   } order_e;

endpackage

// File: rtl/remap_mask_decode.sv
module remap_mask_decode
   import remap_cfg_pkg::*;
#(
   parameter int SEL_W  = 2,
   parameter int MASK_W = SEL_W + SLOT_CODE_W,
   parameter int NSHAPE = 1 << SEL_W
) (
   input  logic                       mm_i,
   input  logic [MASK_W-1:0]          mask_i,
   output logic [NUM_SLOTS-1:0]       en_o,
   output logic [NUM_SLOTS*SEL_W-1:0] sel_o,
   output logic [NSHAPE-1:0]          wr_o
);

   logic [SLOT_CODE_W-1:0] slot_code;
   logic [SEL_W-1:0]       shp_code;
   logic                   code_ok;

   assign slot_code = mask_i[MASK_W-1 -: SLOT_CODE_W];
   assign shp_code  = mask_i[SEL_W-1:0];
   assign code_ok   = (slot_code <= SLOT_CODE_W'(SLOT_OUT1));

   // per-slot enable and selector
   for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_slot
      logic hit;
      assign hit     = code_ok && (slot_code == SLOT_CODE_W'(k));
      assign en_o[k] = mm_i ? hit : mask_i[k];
      if (k < NUM_DIRECT) begin : g_direct
         assign sel_o[k*SEL_W +: SEL_W] = mm_i ? (hit ? shp_code : '0)
                                               : (mask_i[k] ? SEL_W'(k) : '0);
      end else begin : g_nodirect
         assign sel_o[k*SEL_W +: SEL_W] = (mm_i && hit) ? shp_code : '0;
      end
   end

   // which shapes receive new contents; the rest are cleared
   for (genvar s = 0; s < NSHAPE; s++) begin : g_wr
      if (s < NUM_DIRECT) begin : g_direct
         assign wr_o[s] = mm_i ? (shp_code == SEL_W'(s)) : mask_i[s];
      end else begin : g_sel_only
         assign wr_o[s] = mm_i && (shp_code == SEL_W'(s));
      end
   end

endmodule

// File: rtl/remap_shape_build.sv
module remap_shape_build
   import remap_cfg_pkg::*;
#(
   parameter int GRP_W  = 5,
   parameter int DIM_W  = 6,
   parameter int SKIP_W = 2,
   parameter int INV_W  = 3,
   localparam int BASE_W = GRP_W + 1
) (
   input  logic [GRP_W-1:0]  grp_i,
   input  logic [DIM_W-1:0]  dim_i,
   input  logic              yx_i,
   input  logic [SKIP_W-1:0] skip_i,
   input  logic [EW_W-1:0]   ew_i,
   output logic [BASE_W-1:0] base_o,
   output logic [DIM_W-1:0]  xdim_o,
   output logic [DIM_W-1:0]  ydim_o,
   output logic [SKIP_W-1:0] skip_o,
   output logic [INV_W-1:0]  inv_o,
   output logic              order_o,
   output logic [EW_W-1:0]   ew_o
);

   localparam logic [DIM_W-1:0] DIM_ONE = DIM_W'(1);

   order_e  ord;
   elem_w_e ew_code;

   assign ord     = yx_i ? ORD_YX : ORD_XY;
   assign ew_code = elem_w_e'(ew_i);

   assign base_o  = {grp_i, 1'b0};
   assign xdim_o  = (ord == ORD_YX) ? DIM_ONE : dim_i;
   assign ydim_o  = (ord == ORD_YX) ? dim_i   : DIM_ONE;
   assign skip_o  = skip_i;
   assign inv_o   = '0;
   assign order_o = ord;
   assign ew_o    = ew_code;

endmodule

// File: rtl/remap_shape_bank.sv
module remap_shape_bank
   import remap_cfg_pkg::*;
#(
   parameter int SEL_W   = 2,
   parameter int BASE_W  = 6,
   parameter int DIM_W   = 6,
   parameter int SKIP_W  = 2,
   parameter int INV_W   = 3,
   parameter bit RD_PIPE = 1'b0,
   localparam int NSHAPE = 1 << SEL_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              exec_i,
   input  logic [NSHAPE-1:0] wr_i,
   input  logic [BASE_W-1:0] base_i,
   input  logic [DIM_W-1:0]  xdim_i,
   input  logic [DIM_W-1:0]  ydim_i,
   input  logic [SKIP_W-1:0] skip_i,
   input  logic [INV_W-1:0]  inv_i,
   input  logic              order_i,
   input  logic [EW_W-1:0]   ew_i,
   input  logic [SEL_W-1:0]  rd_idx_i,
   output logic [BASE_W-1:0] rd_base_o,
   output logic [DIM_W-1:0]  rd_xdim_o,
   output logic [DIM_W-1:0]  rd_ydim_o,
   output logic [SKIP_W-1:0] rd_skip_o,
   output logic [INV_W-1:0]  rd_inv_o,
   output logic              rd_order_o,
   output logic [EW_W-1:0]   rd_ew_o
);

   // packed layout of one shape word, LSB first
   localparam int OFS_BASE  = 0;
   localparam int OFS_XDIM  = OFS_BASE + BASE_W;
   localparam int OFS_YDIM  = OFS_XDIM + DIM_W;
   localparam int OFS_SKIP  = OFS_YDIM + DIM_W;
   localparam int OFS_INV   = OFS_SKIP + SKIP_W;
   localparam int OFS_ORDER = OFS_INV + INV_W;
   localparam int OFS_EW    = OFS_ORDER + 1;
   localparam int SHP_W     = OFS_EW + EW_W;

   logic [SHP_W-1:0] wr_word;
   logic [SHP_W-1:0] words [NSHAPE];
   logic [SHP_W-1:0] rd_word;
   logic [SHP_W-1:0] rd_out;

   assign wr_word = {ew_i, order_i, inv_i, skip_i, ydim_i, xdim_i, base_i};

   for (genvar s = 0; s < NSHAPE; s++) begin : g_shape
      logic [SHP_W-1:0] q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            q <= '0;
         end else if (exec_i) begin
            q <= wr_i[s] ? wr_word : '0;
         end
      end
      assign words[s] = q;
   end

   assign rd_word = words[rd_idx_i];

   if (RD_PIPE) begin : g_rd_reg
      logic [SHP_W-1:0] rd_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            rd_q <= '0;
         end else begin
            rd_q <= rd_word;
         end
      end
      assign rd_out = rd_q;
   end else begin : g_rd_comb
      assign rd_out = rd_word;
   end

   assign rd_base_o  = rd_out[OFS_BASE  +: BASE_W];
   assign rd_xdim_o  = rd_out[OFS_XDIM  +: DIM_W];
   assign rd_ydim_o  = rd_out[OFS_YDIM  +: DIM_W];
   assign rd_skip_o  = rd_out[OFS_SKIP  +: SKIP_W];
   assign rd_inv_o   = rd_out[OFS_INV   +: INV_W];
   assign rd_order_o = rd_out[OFS_ORDER];
   assign rd_ew_o    = rd_out[OFS_EW    +: EW_W];

endmodule

// File: rtl/remap_cfg_decoder.sv
module remap_cfg_decoder
   import remap_cfg_pkg::*;
#(
   parameter int GRP_W   = 5,
   parameter int DIM_W   = 6,
   parameter int SKIP_W  = 2,
   parameter int INV_W   = 3,
   parameter int SEL_W   = 2,
   parameter bit RD_PIPE = 1'b0
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   exec_i,
   input  logic [GRP_W-1:0]       grp_i,
   input  logic [SEL_W+2:0]       mask_i,
   input  logic [DIM_W-1:0]       dim_i,
   input  logic [1:0]             ew_i,
   input  logic                   yx_i,
   input  logic                   mm_i,
   input  logic [SKIP_W-1:0]      skip_i,
   output logic                   persist_o,
   output logic [4:0]             en_o,
   output logic [5*SEL_W-1:0]     sel_o,
   input  logic [SEL_W-1:0]       rd_idx_i,
   output logic [GRP_W:0]         rd_base_o,
   output logic [DIM_W-1:0]       rd_xdim_o,
   output logic [DIM_W-1:0]       rd_ydim_o,
   output logic [SKIP_W-1:0]      rd_skip_o,
   output logic [INV_W-1:0]       rd_inv_o,
   output logic                   rd_order_o,
   output logic [1:0]             rd_ew_o
);

   localparam int MASK_W = SEL_W + SLOT_CODE_W;
   localparam int NSHAPE = 1 << SEL_W;
   localparam int BASE_W = GRP_W + 1;

   // elaboration-time parameter checks
   if (GRP_W < 1) begin : g_bad_grp
      $error("GRP_W must be at least 1");
   end
   if (DIM_W < 2) begin : g_bad_dim
      $error("DIM_W must be at least 2");
   end
   if (SEL_W < 2) begin : g_bad_sel
      $error("SEL_W must be at least 2 so that four direct shapes exist");
   end
   if (SKIP_W < 1 || INV_W < 1) begin : g_bad_fields
      $error("SKIP_W and INV_W must be at least 1");
   end
   if (MASK_W < NUM_SLOTS) begin : g_bad_mask
      $error("mask narrower than the slot count");
   end

   // decoded mask
   logic [NUM_SLOTS-1:0]       dec_en;
   logic [NUM_SLOTS*SEL_W-1:0] dec_sel;
   logic [NSHAPE-1:0]          dec_wr;

   remap_mask_decode #(
      .SEL_W  (SEL_W),
      .MASK_W (MASK_W),
      .NSHAPE (NSHAPE)
   ) u_decode (
      .mm_i   (mm_i),
      .mask_i (mask_i),
      .en_o   (dec_en),
      .sel_o  (dec_sel),
      .wr_o   (dec_wr)
   );

   // new shape contents
   logic [BASE_W-1:0] nb_base;
   logic [DIM_W-1:0]  nb_xdim;
   logic [DIM_W-1:0]  nb_ydim;
   logic [SKIP_W-1:0] nb_skip;
   logic [INV_W-1:0]  nb_inv;
   logic              nb_order;
   logic [EW_W-1:0]   nb_ew;

   remap_shape_build #(
      .GRP_W  (GRP_W),
      .DIM_W  (DIM_W),
      .SKIP_W (SKIP_W),
      .INV_W  (INV_W)
   ) u_build (
      .grp_i   (grp_i),
      .dim_i   (dim_i),
      .yx_i    (yx_i),
      .skip_i  (skip_i),
      .ew_i    (ew_i),
      .base_o  (nb_base),
      .xdim_o  (nb_xdim),
      .ydim_o  (nb_ydim),
      .skip_o  (nb_skip),
      .inv_o   (nb_inv),
      .order_o (nb_order),
      .ew_o    (nb_ew)
   );

   remap_shape_bank #(
      .SEL_W   (SEL_W),
      .BASE_W  (BASE_W),
      .DIM_W   (DIM_W),
      .SKIP_W  (SKIP_W),
      .INV_W   (INV_W),
      .RD_PIPE (RD_PIPE)
   ) u_bank (
      .clk        (clk),
      .rst_n      (rst_n),
      .exec_i     (exec_i),
      .wr_i       (dec_wr),
      .base_i     (nb_base),
      .xdim_i     (nb_xdim),
      .ydim_i     (nb_ydim),
      .skip_i     (nb_skip),
      .inv_i      (nb_inv),
      .order_i    (nb_order),
      .ew_i       (nb_ew),
      .rd_idx_i   (rd_idx_i),
      .rd_base_o  (rd_base_o),
      .rd_xdim_o  (rd_xdim_o),
      .rd_ydim_o  (rd_ydim_o),
      .rd_skip_o  (rd_skip_o),
      .rd_inv_o   (rd_inv_o),
      .rd_order_o (rd_order_o),
      .rd_ew_o    (rd_ew_o)
   );

   // state word
   logic                       persist_q;
   logic [NUM_SLOTS-1:0]       en_q;
   logic [NUM_SLOTS*SEL_W-1:0] sel_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         persist_q <= 1'b0;
         en_q      <= '0;
         sel_q     <= '0;
      end else if (exec_i) begin
         persist_q <= mm_i;
         en_q      <= dec_en;
         sel_q     <= dec_sel;
      end
   end

   assign persist_o = persist_q;
   assign en_o      = en_q;
   assign sel_o     = sel_q;

endmodule

// File: rtl/remap_cfg_checker.sv
module remap_cfg_checker #(
   parameter int SEL_W = 2
) (
   input logic               clk,
   input logic               rst_n,
   input logic               exec_i,
   input logic               mm_i,
   input logic [SEL_W+2:0]   mask_i,
   input logic               persist_o,
   input logic [4:0]         en_o,
   input logic [5*SEL_W-1:0] sel_o
);

   logic [2:0] slot_code;
   assign slot_code = mask_i[SEL_W+2 -: 3];

   p_persist_r2: assert property (@(posedge clk) disable iff (!rst_n)
      exec_i |=> persist_o == $past(mm_i));

   p_en_direct_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (exec_i && !mm_i) |=> en_o == $past(mask_i[4:0]));

   p_out0_sel_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (exec_i && !mm_i && mask_i[3]) |=> sel_o[3*SEL_W +: SEL_W] == SEL_W'(3));

   p_out1_sel_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (exec_i && !mm_i) |=> sel_o[4*SEL_W +: SEL_W] == '0);

   p_en_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (exec_i && mm_i) |=> $onehot0(en_o));

   p_out0_pick_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (exec_i && mm_i && slot_code == 3'd3)
      |=> (en_o == 5'b01000) && (sel_o[3*SEL_W +: SEL_W] == $past(mask_i[SEL_W-1:0])));

   p_bad_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (exec_i && mm_i && slot_code > 3'd4) |=> (en_o == '0) && (sel_o == '0));

   p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !exec_i |=> $stable(en_o) && $stable(sel_o) && $stable(persist_o));

endmodule

bind remap_cfg_decoder remap_cfg_checker #(.SEL_W(SEL_W)) u_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .exec_i    (exec_i),
   .mm_i      (mm_i),
   .mask_i    (mask_i),
   .persist_o (persist_o),
   .en_o      (en_o),
   .sel_o     (sel_o)
);

// File: tb/test_remap_cfg_decoder.sv
module test_remap_cfg_decoder;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       exec_i = 1'b0;
   logic [4:0] grp_i = '0;
   logic [4:0] mask_i = '0;
   logic [5:0] dim_i = '0;
   logic [1:0] ew_i = '0;
   logic       yx_i = 1'b0;
   logic       mm_i = 1'b0;
   logic [1:0] skip_i = '0;
   logic       persist_o;
   logic [4:0] en_o;
   logic [9:0] sel_o;
   logic [1:0] rd_idx_i = '0;
   logic [5:0] rd_base_o;
   logic [5:0] rd_xdim_o;
   logic [5:0] rd_ydim_o;
   logic [1:0] rd_skip_o;
   logic [2:0] rd_inv_o;
   logic       rd_order_o;
   logic [1:0] rd_ew_o;

   int n_vec = 0;
   int n_bad = 0;

   always #4 clk = ~clk;

   remap_cfg_decoder i_remap_cfg_decoder (
      .clk        (clk),
      .rst_n      (rst_n),
      .exec_i     (exec_i),
      .grp_i      (grp_i),
      .mask_i     (mask_i),
      .dim_i      (dim_i),
      .ew_i       (ew_i),
      .yx_i       (yx_i),
      .mm_i       (mm_i),
      .skip_i     (skip_i),
      .persist_o  (persist_o),
      .en_o       (en_o),
      .sel_o      (sel_o),
      .rd_idx_i   (rd_idx_i),
      .rd_base_o  (rd_base_o),
      .rd_xdim_o  (rd_xdim_o),
      .rd_ydim_o  (rd_ydim_o),
      .rd_skip_o  (rd_skip_o),
      .rd_inv_o   (rd_inv_o),
      .rd_order_o (rd_order_o),
      .rd_ew_o    (rd_ew_o)
   );

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // drive one execute strobe; state is committed at the edge in between
   task automatic issue(input logic mm, input logic [4:0] mask, input logic [4:0] grp,
                        input logic [5:0] dim, input logic [1:0] ew, input logic yx,
                        input logic [1:0] skip);
      @(negedge clk);
      mm_i = mm; mask_i = mask; grp_i = grp; dim_i = dim;
      ew_i = ew; yx_i = yx; skip_i = skip; exec_i = 1'b1;
      @(negedge clk);
      exec_i = 1'b0;
   endtask

   task automatic chk_state(input string req, input logic p, input logic [4:0] en,
                            input logic [9:0] sel);
      chk(req, "persist", persist_o, p);
      chk(req, "enable", en_o, en);
      chk(req, "selectors", sel_o, sel);
   endtask

   task automatic chk_shape(input string req, input logic [1:0] idx,
                            input logic [5:0] base, input logic [5:0] x, input logic [5:0] y,
                            input logic [1:0] skip, input logic [1:0] ew, input logic ord);
      rd_idx_i = idx;
      #1;
      chk(req, $sformatf("shape%0d base", idx), rd_base_o, base);
      chk(req, $sformatf("shape%0d xdim", idx), rd_xdim_o, x);
      chk(req, $sformatf("shape%0d ydim", idx), rd_ydim_o, y);
      chk(req, $sformatf("shape%0d skip", idx), rd_skip_o, skip);
      chk(req, $sformatf("shape%0d ew", idx), rd_ew_o, ew);
      chk(req, $sformatf("shape%0d order", idx), rd_order_o, ord);
      chk(req, $sformatf("shape%0d inv", idx), rd_inv_o, 0);
   endtask

   task automatic chk_zero(input string req, input logic [1:0] idx);
      chk_shape(req, idx, 0, 0, 0, 0, 0, 0);
   endtask

   // R1: all state clear after reset
   task automatic t_reset_state();
      chk_state("R1", 1'b0, 5'b0, 10'h000);
      for (int s = 0; s < 4; s++) chk_zero("R1", 2'(s));
   endtask

   // R2 R3 R4 R7 R8: enable mode, four slots on
   task automatic t_enable_mask();
      issue(1'b0, 5'b01111, 5'd1, 6'd5, 2'd0, 1'b0, 2'd0);
      chk_state("R3_R4", 1'b0, 5'b01111, 10'h0E4);
      for (int s = 0; s < 4; s++) chk_shape("R7_R8", 2'(s), 6'd2, 6'd5, 6'd1, 2'd0, 2'd0, 1'b0);
   endtask

   // R4 R8 R9 R10: sparse mask with out1, axis swap, skip and 8-bit indices
   task automatic t_sparse_mask();
      issue(1'b0, 5'b10010, 5'd8, 6'd3, 2'd3, 1'b1, 2'd2);
      chk_state("R4", 1'b0, 5'b10010, 10'h004);
      chk_shape("R9", 2'd1, 6'd16, 6'd1, 6'd3, 2'd2, 2'd3, 1'b1);
      chk_zero("R10", 2'd0);
      chk_zero("R10", 2'd2);
      chk_zero("R10", 2'd3);
   endtask

   // R13: readback follows the index with no clock edge
   task automatic t_readback();
      @(negedge clk);
      rd_idx_i = 2'd1; #1; chk("R13", "base idx1", rd_base_o, 6'd16);
      rd_idx_i = 2'd0; #1; chk("R13", "base idx0", rd_base_o, 6'd0);
      rd_idx_i = 2'd1; #1; chk("R13", "ydim idx1", rd_ydim_o, 6'd3);
   endtask

   // R2 R5 R11: select mode targeting out0 with shape 2
   task automatic t_select_out0();
      issue(1'b1, 5'b01110, 5'd1, 6'd5, 2'd1, 1'b0, 2'd1);
      chk_state("R2_R5", 1'b1, 5'b01000, 10'h080);
      chk_shape("R11", 2'd2, 6'd2, 6'd5, 6'd1, 2'd1, 2'd1, 1'b0);
      chk_zero("R11", 2'd0);
      chk_zero("R11", 2'd1);
      chk_zero("R11", 2'd3);
   endtask

   // R5 R11: select mode targeting out1 with shape 3
   task automatic t_select_out1();
      issue(1'b1, 5'b10011, 5'd3, 6'd7, 2'd2, 1'b0, 2'd3);
      chk_state("R5", 1'b1, 5'b10000, 10'h300);
      chk_shape("R11", 2'd3, 6'd6, 6'd7, 6'd1, 2'd3, 2'd2, 1'b0);
      chk_zero("R11", 2'd2);
   endtask

   // R6: out-of-range slot code, shape still written; R7 at the widest group
   task automatic t_bad_code();
      issue(1'b1, 5'b11101, 5'd31, 6'd63, 2'd0, 1'b1, 2'd0);
      chk_state("R6", 1'b1, 5'b00000, 10'h000);
      chk_shape("R6_R7", 2'd1, 6'd62, 6'd1, 6'd63, 2'd0, 2'd0, 1'b1);
      chk_zero("R6", 2'd3);
   endtask

   // R12: inputs move while the strobe stays low
   task automatic t_hold();
      issue(1'b0, 5'b01111, 5'd1, 6'd5, 2'd0, 1'b0, 2'd0);
      @(negedge clk);
      mm_i = 1'b1; mask_i = 5'b11111; grp_i = 5'd30; dim_i = 6'd40;
      ew_i = 2'd2; yx_i = 1'b1; skip_i = 2'd3;
      repeat (4) @(negedge clk);
      chk_state("R12", 1'b0, 5'b01111, 10'h0E4);
      chk_shape("R12", 2'd0, 6'd2, 6'd5, 6'd1, 2'd0, 2'd0, 1'b0);
      chk_shape("R12", 2'd3, 6'd2, 6'd5, 6'd1, 2'd0, 2'd0, 1'b0);
   endtask

   // R1: reset after activity clears everything again
   task automatic t_mid_reset();
      issue(1'b1, 5'b00110, 5'd9, 6'd4, 2'd1, 1'b0, 2'd1);
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      chk_state("R1", 1'b0, 5'b0, 10'h000);
      for (int s = 0; s < 4; s++) chk_zero("R1", 2'(s));
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset_state();
      t_enable_mask();
      t_sparse_mask();
      t_readback();
      t_select_out0();
      t_select_out1();
      t_bad_code();
      t_hold();
      t_mid_reset();
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule